// File: doc/BRIEF.md
# Two-Bank Clock Fanout Control Path

This block is the digital logic behind a clock fanout buffer with two banks of outputs and a separate feedback output. It picks its source clock, either the phase-locked loop clock or the reference clock when the loop is bypassed for test. From that source it drives bank A, bank B and the feedback output. Bank B runs at the bank A rate or at half of it. In both settings its rising edges coincide with bank A rising edges.

A stop control parks both banks low without truncating any pulse. The stop request is sampled on the falling edge of the source, so a gate only opens or closes while the clock is low. A high-impedance control turns off the output drivers of both banks at once, and does so asynchronously. Each bank reports its drive state as an enable output next to its data. The feedback output is never stopped or disabled, so the loop stays locked while downstream logic is quiet. Raising the high-impedance control and the bypass control together acts as an asynchronous reset.

Top module: `clkfan_ctrl`

## Requirements
- R1: With `bypass_i` high the source clock is `ref_clk`. With it low the source is `vco_clk`. `fb_o` carries the selected source.
- R2: While running, every bank A output is high in the source high phase and low in the source low phase.
- R3: With the bank B divide select low, bank B matches bank A. With it high, bank B changes level on each source rising edge. After a reset, the first source rising edge drives bank B high together with bank A.
- R4: `stop_i` is sampled on source falling edges. A sampled 1 holds bank A low from the next source cycle on. A sampled 0 lets bank A rise again at the next source rising edge.
- R5: Bank B takes a new stop state or a new divide select only at a source falling edge where bank B is low. In divided mode, a change requested while bank B is high waits one more source cycle, so no bank B high pulse is cut short.
- R6: `hiz_i` high drives `bank_a_en_o` and `bank_b_en_o` low at once, whatever the stop state. The data outputs keep running underneath.
- R7: `fb_o` keeps toggling while `stop_i` or `hiz_i` is high.
- R8: `hiz_i` and `bypass_i` both high form an asynchronous reset. During reset both enables are low, the gates are open, bank B is undivided and the divider is cleared.
- R9: With all controls low, the outputs are enabled and bank A and bank B run at the full rate from `vco_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Clock from the phase-locked loop |
| ref_clk | input | 1 | Reference clock, used as source in bypass |
| bypass_i | input | 1 | 1 selects ref_clk as source (test mode) |
| half_b_i | input | 1 | 1 runs bank B at half the bank A rate |
| stop_i | input | 1 | 1 parks both banks low at the next safe point |
| hiz_i | input | 1 | 1 disables the bank output drivers |
| bank_a_o | output | NUM_A (5) | Bank A clock outputs |
| bank_a_en_o | output | 1 | Bank A driver enable (0 = high impedance) |
| bank_b_o | output | NUM_B (5) | Bank B clock outputs |
| bank_b_en_o | output | 1 | Bank B driver enable (0 = high impedance) |
| fb_o | output | 1 | Feedback clock, never gated |

## Verification
The bench requests a stop and a restart while the divided bank B is high. A design that applied the change at once would cut that pulse short or open the gate in mid-pulse, and bank B would then fall out of step with bank A. It also switches the divide select on both odd and even source cycles. It resets in the middle of divided operation and checks that the first bank B edge lines up with bank A; a divider that was not cleared would start in opposite phase. The feedback output is watched while the banks are stopped and tri-stated, and the source select is probed by silencing one clock at a time.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  // Bank B may take a new stop/divide state only while it is low now and
  // stays low under the requested setting until the next rising edge.
  function automatic logic bank_b_may_update(input logic div_lvl,
                                             input logic half_now,
                                             input logic half_req);
    return !div_lvl || (!half_now && !half_req);
  endfunction

  // Level presented on every bank B pin.
  function automatic logic bank_b_level(input logic src,
                                        input logic div_lvl,
                                        input logic half_now,
                                        input logic run);
    return run && (half_now ? div_lvl : src);
  endfunction

endpackage

// File: rtl/clkfan_src_sel.sv
module clkfan_src_sel (
  input  logic vco_clk,
  input  logic ref_clk,
  input  logic bypass_i,
  input  logic hiz_i,
  output logic src_clk,
  output logic rst_o
);

  assign src_clk = bypass_i ? ref_clk : vco_clk;
  // Test mode together with driver disable clears the control state.
  assign rst_o   = bypass_i & hiz_i;

endmodule

// File: rtl/clkfan_gate_ctrl.sv
module clkfan_gate_ctrl
  import clkfan_pkg::*;
(
  input  logic src_clk,
  input  logic rst,
  input  logic stop_i,
  input  logic half_i,
  output logic div_q,
  output logic run_a_q,
  output logic run_b_q,
  output logic half_q,
  output logic b_upd
);

  // Divider runs on every source rising edge, also while stopped.
  always_ff @(posedge src_clk or posedge rst) begin
    if (rst) div_q <= 1'b0;
    else     div_q <= ~div_q;
  end

  // Bank A gate: falling edge, so it moves only inside a low phase.
  always_ff @(negedge src_clk or posedge rst) begin
    if (rst) run_a_q <= 1'b1;
    else     run_a_q <= ~stop_i;
  end

  assign b_upd = bank_b_may_update(div_q, half_q, half_i);

  // Bank B gate and divide select move together, only when B is low.
  always_ff @(negedge src_clk or posedge rst) begin
    if (rst) begin
      run_b_q <= 1'b1;
      half_q  <= 1'b0;
    end else if (b_upd) begin
      run_b_q <= ~stop_i;
      half_q  <= half_i;
    end
  end

endmodule

// File: rtl/clkfan_bank_drv.sv
module clkfan_bank_drv #(
  parameter int WIDTH = 5
) (
  input  logic             level_i,
  input  logic             hiz_i,
  output logic [WIDTH-1:0] q_o,
  output logic             en_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign q_o[i] = level_i;
  end

  assign en_o = ~hiz_i;

endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
  import clkfan_pkg::*;
#(
  parameter int NUM_A = 5,
  parameter int NUM_B = 5
) (
  input  logic             vco_clk,
  input  logic             ref_clk,
  input  logic             bypass_i,
  input  logic             half_b_i,
  input  logic             stop_i,
  input  logic             hiz_i,
  output logic [NUM_A-1:0] bank_a_o,
  output logic             bank_a_en_o,
  output logic [NUM_B-1:0] bank_b_o,
  output logic             bank_b_en_o,
  output logic             fb_o
);

  logic src_clk;
  logic rst_w;
  logic div_q;
  logic run_a_q;
  logic run_b_q;
  logic half_q;
  logic b_upd;
  logic lvl_a;
  logic lvl_b;

  clkfan_src_sel u_src (
    .vco_clk  (vco_clk),
    .ref_clk  (ref_clk),
    .bypass_i (bypass_i),
    .hiz_i    (hiz_i),
    .src_clk  (src_clk),
    .rst_o    (rst_w)
  );

  clkfan_gate_ctrl u_gate (
    .src_clk (src_clk),
    .rst     (rst_w),
    .stop_i  (stop_i),
    .half_i  (half_b_i),
    .div_q   (div_q),
    .run_a_q (run_a_q),
    .run_b_q (run_b_q),
    .half_q  (half_q),
    .b_upd   (b_upd)
  );

  assign lvl_a = src_clk & run_a_q;
  assign lvl_b = bank_b_level(src_clk, div_q, half_q, run_b_q);

  clkfan_bank_drv #(.WIDTH(NUM_A)) u_bank_a (
    .level_i (lvl_a),
    .hiz_i   (hiz_i),
    .q_o     (bank_a_o),
    .en_o    (bank_a_en_o)
  );

  clkfan_bank_drv #(.WIDTH(NUM_B)) u_bank_b (
    .level_i (lvl_b),
    .hiz_i   (hiz_i),
    .q_o     (bank_b_o),
    .en_o    (bank_b_en_o)
  );

  // Feedback path bypasses every gate and the driver disable.
  assign fb_o = src_clk;

endmodule

// File: rtl/clkfan_ctrl_chk.sv
module clkfan_ctrl_chk (
  input logic src_clk,
  input logic rst,
  input logic stop_i,
  input logic hiz_i,
  input logic div_q,
  input logic run_b_q,
  input logic half_q,
  input logic bank_a_lvl,
  input logic bank_a_en_o,
  input logic bank_b_en_o,
  input logic fb_o
);

  // R3: divided bank B source alternates on every source rising edge
  p_div_alternates_r3: assert property (@(posedge src_clk) disable iff (rst)
    !$past(rst) |-> (div_q != $past(div_q)));

  // R4: bank A level before a falling edge reflects the stop sampled one falling edge earlier
  p_stop_parks_a_r4: assert property (@(negedge src_clk) disable iff (rst)
    !$past(rst) |-> (bank_a_lvl != $past(stop_i)));

  // R5: bank B gate moves in divided mode only while the divider is low
  p_bgate_low_r5: assert property (@(posedge src_clk) disable iff (rst)
    (!$past(rst) && $past(half_q) && (run_b_q != $past(run_b_q))) |-> !div_q);

  // R5: divide select switches only while the divider is low
  p_mode_switch_low_r5: assert property (@(posedge src_clk) disable iff (rst)
    (!$past(rst) && (half_q != $past(half_q))) |-> !div_q);

  // R6: driver disable turns both enables off
  p_hiz_disables_r6: assert property (@(posedge src_clk) disable iff (rst)
    hiz_i |-> (!bank_a_en_o && !bank_b_en_o));

  // R7: feedback is high before each falling edge even while stopped or disabled
  p_fb_free_r7: assert property (@(negedge src_clk) disable iff (rst)
    (stop_i || hiz_i) |-> fb_o);

endmodule

bind clkfan_ctrl clkfan_ctrl_chk u_chk (
  .src_clk     (src_clk),
  .rst         (rst_w),
  .stop_i      (stop_i),
  .hiz_i       (hiz_i),
  .div_q       (div_q),
  .run_b_q     (run_b_q),
  .half_q      (half_q),
  .bank_a_lvl  (bank_a_o[0]),
  .bank_a_en_o (bank_a_en_o),
  .bank_b_en_o (bank_b_en_o),
  .fb_o        (fb_o)
);

// File: tb/clkfan_ctrl_bench.sv
module clkfan_ctrl_bench;

  localparam int NA = 5;
  localparam int NB = 5;

  typedef struct {
    logic  a;
    logic  b;
    logic  fb;
    logic  en;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic ref_run = 1'b1;
  logic vco_run = 1'b1;
  logic vco_clk, ref_clk;
  logic bypass_i = 1'b1;
  logic half_b_i = 1'b0;
  logic stop_i   = 1'b0;
  logic hiz_i    = 1'b1;
  logic [NA-1:0] bank_a_o;
  logic [NB-1:0] bank_b_o;
  logic bank_a_en_o, bank_b_en_o, fb_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  exp_t q[$];

  // bench model of the requirements
  logic m_a_run, m_b_run, m_b_half, byp_m;
  int   m_k;

  always #10 clk = ~clk;
  assign ref_clk = clk & ref_run;
  assign vco_clk = clk & vco_run;

  clkfan_ctrl #(.NUM_A(NA), .NUM_B(NB)) u_clkfan_ctrl (
    .vco_clk     (vco_clk),
    .ref_clk     (ref_clk),
    .bypass_i    (bypass_i),
    .half_b_i    (half_b_i),
    .stop_i      (stop_i),
    .hiz_i       (hiz_i),
    .bank_a_o    (bank_a_o),
    .bank_a_en_o (bank_a_en_o),
    .bank_b_o    (bank_b_o),
    .bank_b_en_o (bank_b_en_o),
    .fb_o        (fb_o)
  );

  task automatic push(input logic a, input logic b, input logic fb,
                      input logic en, input string tag);
    exp_t e;
    e.a = a; e.b = b; e.fb = fb; e.en = en; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic direct_check(input string tag, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, expv);
    end
  endtask

  // monitor: pops one expectation at each high-phase and low-phase sample point
  task automatic pop_check();
    exp_t e;
    logic [NA-1:0] ea;
    logic [NB-1:0] eb;
    if (q.size() == 0) return;
    e  = q.pop_front();
    ea = {NA{e.a}};
    eb = {NB{e.b}};
    total++;
    if (bank_a_o !== ea || bank_b_o !== eb || fb_o !== e.fb ||
        bank_a_en_o !== e.en || bank_b_en_o !== e.en) begin
      bad++;
      $display("FAIL %s t=%0t actual a=%b b=%b fb=%b en=%b%b expected a=%b b=%b fb=%b en=%b",
               e.tag, $time, bank_a_o, bank_b_o, fb_o, bank_a_en_o, bank_b_en_o,
               ea, eb, e.fb, e.en);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #5 pop_check();
      @(negedge clk); #5 pop_check();
    end
  end

  // R8: reset through the control pair, two source cycles
  task automatic do_reset();
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #2;
      hiz_i = 1'b1; bypass_i = 1'b1; stop_i = 1'b0; half_b_i = 1'b0;
      push(1'b1, 1'b1, 1'b1, 1'b0, "R8");
      push(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    end
    m_a_run = 1'b1; m_b_run = 1'b1; m_b_half = 1'b0; m_k = 0;
  endtask

  // driver: one source cycle with the given controls
  task automatic cyc(input logic stp, input logic hlf, input logic hz, input string tag);
    logic bh, bl, allow;
    @(posedge clk); #2;
    bypass_i = byp_m;
    stop_i   = stp;
    half_b_i = hlf;
    hiz_i    = hz;
    if (m_b_half) begin
      bh = m_b_run & m_k[0];
      bl = bh;
    end else begin
      bh = m_b_run;
      bl = 1'b0;
    end
    push(m_a_run, bh, 1'b1, ~hz, tag);
    push(1'b0,    bl, 1'b0, ~hz, tag);
    // state after the falling edge of this cycle
    allow = !m_k[0] || (!m_b_half && !hlf);
    m_a_run = ~stp;
    if (allow) begin
      m_b_run  = ~stp;
      m_b_half = hlf;
    end
    m_k++;
  endtask

  initial begin
    #400_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    byp_m = 1'b1;
    repeat (2) @(posedge clk);
    do_reset();
    repeat (4) cyc(0, 0, 0, "R2");          // full rate, both banks equal
    repeat (6) cyc(0, 1, 0, "R3");          // divide requested on an even cycle
    repeat (3) cyc(1, 1, 0, "R4");          // stop while divided bank low
    repeat (4) cyc(0, 1, 0, "R5");          // restart requested with B high
    repeat (3) cyc(1, 1, 0, "R5");          // stop requested with B high
    repeat (3) cyc(0, 1, 0, "R5");
    repeat (4) cyc(0, 0, 0, "R5");          // undivide requested with B high
    repeat (3) cyc(1, 0, 0, "R4");          // full-rate stop
    repeat (2) cyc(0, 0, 0, "R4");
    byp_m = 1'b0;
    repeat (2) cyc(0, 0, 0, "R7");
    repeat (2) cyc(0, 1, 1, "R6");          // driver disable
    repeat (2) cyc(1, 1, 1, "R6");          // disable wins over stop
    repeat (2) cyc(0, 1, 1, "R7");
    repeat (3) cyc(0, 1, 0, "R6");
    do_reset();                              // reset in the middle of divided mode
    byp_m = 1'b0;
    repeat (3) cyc(0, 0, 0, "R9");          // all controls low, loop clock
    repeat (4) cyc(0, 1, 0, "R8");
    do_reset();
    byp_m = 1'b1;
    repeat (4) cyc(0, 1, 0, "R8");          // divided restart aligned with bank A
    repeat (2) cyc(0, 0, 0, "R2");
    wait (q.size() == 0);

    // R1: source select, probed by silencing one clock at a time
    @(posedge clk); #2;
    bypass_i = 1'b1; ref_run = 1'b0;
    #3 direct_check("R1 ref silent", fb_o, 1'b0);
    @(negedge clk); #5 direct_check("R1 ref silent", fb_o, 1'b0);
    @(posedge clk); #2;
    bypass_i = 1'b0;
    #3 direct_check("R1 vco high", fb_o, 1'b1);
    @(negedge clk); #5 direct_check("R1 vco low", fb_o, 1'b0);
    @(posedge clk); #2;
    vco_run = 1'b0; ref_run = 1'b1; bypass_i = 1'b1;
    #3 direct_check("R1 ref high", fb_o, 1'b1);
    @(negedge clk); #5 direct_check("R1 ref low", fb_o, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule